// File: doc/BRIEF.md
# PN-Code Chip Spreader

This block is the transmit side of a direct-sequence spread-spectrum link. It takes data bits one at a time over a valid/ready handshake and replaces each symbol with a pseudo-noise chip sequence taken from a 64-chip code word. The chips come out one at a time. Each chip lasts a fixed number of clock cycles and is marked by a one-cycle `chip_en` strobe. An oversampling phase count goes with it, so that a correlator further down the line can align its sampling grid to the chip stream.

A small 3-bit mode register chooses how the code word is used. The full 64 chips can carry one bit. One 32-chip half can carry one bit, with the two halves acting as the codes for 1 and 0. At double rate a pair of bits picks a half and a polarity, so 32 chips carry two bits and the bit throughput at the same chip rate is twice the normal 32-chip figure. Combinations that make no sense are refused and flagged, and the last good mode stays in force. A new mode applies from the next symbol that starts.

Top module: `pn_spreader`

## Requirements
- R1: The mode register reads back on `mode_rdata` with the code-width select in bit 2 (1 = 32 chips, 0 = 64 chips), the rate select in bit 1 (1 = double rate), the 12x-sample select in bit 0, and bits 7:3 always zero, whatever was written there.
- R2: A write whose low three bits are 001, 010, 011 or 111 sets `mode_err` and leaves the stored mode unchanged. A write of 000, 100, 101 or 110 stores the mode and clears `mode_err`.
- R3: In mode 000 one accepted bit produces 64 chips. Bit 1 sends the code word from bit 63 down to bit 0, and bit 0 sends its bitwise inverse.
- R4: In modes 100 and 101 one accepted bit produces 32 chips, MSB first. Bit 1 sends code bits 63:32 and bit 0 sends code bits 31:0.
- R5: In mode 110 two accepted bits produce 32 chips. The first bit picks the half (1 = bits 63:32, 0 = bits 31:0). The second bit picks the polarity (1 = true, 0 = inverted).
- R6: Every chip lasts 12*SAMPLE_CYC cycles. `chip_en` is high only in the first cycle of each chip, and `chip_out` holds the chip value for the whole chip.
- R7: During a mode-101 symbol `os_phase` counts 0..11 across each chip. In every other mode it counts 0..5, advancing every 2*SAMPLE_CYC cycles. It is 0 when no symbol is being sent.
- R8: `bit_ready` is high while idle and in the final cycle of a symbol. In double-rate mode it is also high while no first bit of a pair is held. A bit accepted in the final cycle starts the next symbol with no gap between chips.
- R9: A mode written while a symbol is being sent does not alter that symbol. It applies to the next symbol.
- R10: After reset the stored mode is 000, `mode_err` is 0, no chip is sent and `bit_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| mode_rdata | output | 8 | Stored mode, reserved bits zero |
| mode_err | output | 1 | Last mode write was an illegal combination |
| code_word | input | 64 | Spreading code word |
| bit_valid | input | 1 | Data bit offered |
| bit_data | input | 1 | Data bit value |
| bit_ready | output | 1 | Spreader takes the offered bit this cycle |
| chip_en | output | 1 | First cycle of a chip |
| chip_out | output | 1 | Current chip value |
| os_phase | output | 4 | Oversampling phase within the current chip |

## Verification
A corrupted shift register or chip index shows up on `chip_out` or in the chip count before the symbol ends. A symbol with a wrong length is caught at the latest within two chip periods after it should have finished, by a late or missing strobe or by `bit_ready` rising at the wrong cycle. A wrong latched mode appears in the first chip as the wrong half or polarity, and in the first chip period as an `os_phase` that exceeds its range. A mode register that accepts an illegal value is visible on `mode_rdata` and `mode_err` one cycle after the write.

// File: rtl/pn_spread_pkg.sv
package pn_spread_pkg;

    localparam int CODE_W  = 64;
    localparam int HALF_W  = CODE_W / 2;
    localparam int IDX_W   = $clog2(CODE_W);
    localparam int REG_W   = 8;
    localparam int OSP_W   = 4;

    // bit 2: code width, bit 1: rate, bit 0: fine sampling
    typedef struct packed {
        logic wide32;
        logic dual;
        logic fine;
    } mode_t;

    typedef enum logic [1:0] {
        SYM_W64 = 2'd0,
        SYM_N32 = 2'd1,
        SYM_DDR = 2'd2
    } sym_kind_e;

    typedef struct packed {
        logic [CODE_W-1:0] chips;  // left aligned, sent from MSB
        logic              long64;
        logic              os12;
    } sym_t;

    function automatic logic mode_ok(mode_t m);
        logic bad;
        bad = (!m.wide32 && (m.dual || m.fine)) || (m.wide32 && m.dual && m.fine);
        return !bad;
    endfunction

    function automatic sym_kind_e kind_of(mode_t m);
        if (!m.wide32)   return SYM_W64;
        else if (m.dual) return SYM_DDR;
        else             return SYM_N32;
    endfunction

    function automatic sym_t build_sym(mode_t m, logic [CODE_W-1:0] code,
                                       logic b_hold, logic b_now);
        sym_t              s;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] pick;
        hi     = code[CODE_W-1:HALF_W];
        lo     = code[HALF_W-1:0];
        pick   = b_hold ? hi : lo;
        s      = '0;
        s.os12 = (kind_of(m) == SYM_N32) && m.fine;
        unique case (kind_of(m))
            SYM_W64: begin
                s.chips  = b_now ? code : ~code;
                s.long64 = 1'b1;
            end
            SYM_N32: begin
                s.chips  = {(b_now ? hi : lo), {HALF_W{1'b0}}};
                s.long64 = 1'b0;
            end
            default: begin
                s.chips  = {(b_now ? pick : ~pick), {HALF_W{1'b0}}};
                s.long64 = 1'b0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pn_mode_reg.sv
module pn_mode_reg
    import pn_spread_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output mode_t            mode,
    output logic [REG_W-1:0] rdata,
    output logic             err
);

    mode_t wr_mode;
    logic  rsvd_seen;

    assign wr_mode   = mode_t'(wdata[2:0]);
    assign rsvd_seen = |wdata[REG_W-1:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            err  <= 1'b0;
        end else if (we) begin
            if (mode_ok(wr_mode)) begin
                mode <= wr_mode;
                err  <= 1'b0;
            end else begin
                err  <= 1'b1;
            end
        end
    end

    assign rdata = {{(REG_W-3){1'b0}}, mode};

    assert_bad_write_flag_R2: assert property (@(posedge clk) disable iff (rst)
        we && !mode_ok(wr_mode) |=> err);
    assert_bad_write_hold_R2: assert property (@(posedge clk) disable iff (rst)
        we && !mode_ok(wr_mode) |=> mode == $past(mode));
    assert_good_write_clear_R2: assert property (@(posedge clk) disable iff (rst)
        we && mode_ok(wr_mode) |=> !err && mode == $past(wr_mode));
    assert_rsvd_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        we && rsvd_seen && mode_ok(wr_mode) |=> rdata[2:0] == $past(wdata[2:0]));

endmodule

// File: rtl/pn_sym_builder.sv
module pn_sym_builder
    import pn_spread_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic [CODE_W-1:0] code,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic              seq_busy,
    input  logic              seq_last,
    output logic              bit_ready,
    output logic              load,
    output sym_t              sym
);

    logic half_have;
    logic half_bit;
    logic ddr;
    logic take;
    logic first_of_pair;

    assign ddr           = (kind_of(mode) == SYM_DDR);
    assign first_of_pair = ddr && !half_have;
    assign bit_ready     = !seq_busy || seq_last || first_of_pair;
    assign take          = bit_valid && bit_ready;
    assign load          = take && !first_of_pair;
    assign sym           = build_sym(mode, code, half_bit, bit_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_have <= 1'b0;
            half_bit  <= 1'b0;
        end else if (take) begin
            if (first_of_pair) begin
                half_have <= 1'b1;
                half_bit  <= bit_data;
            end else begin
                half_have <= 1'b0;
            end
        end
    end

    assert_pair_first_held_R5: assert property (@(posedge clk) disable iff (rst)
        take && first_of_pair |=> half_have && half_bit == $past(bit_data));
    assert_pair_consumed_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> !half_have);

endmodule

// File: rtl/pn_chip_seq.sv
module pn_chip_seq
    import pn_spread_pkg::*;
#(
    parameter int SAMPLE_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  sym_t             sym,
    output logic             busy,
    output logic             last,
    output logic             chip_en,
    output logic             chip_out,
    output logic [OSP_W-1:0] os_phase
);

    localparam int CPC   = 12 * SAMPLE_CYC;
    localparam int CNT_W = $clog2(CPC);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CPC - 1);
    localparam logic [CNT_W-1:0] DIV12   = CNT_W'(SAMPLE_CYC);
    localparam logic [CNT_W-1:0] DIV6    = CNT_W'(2 * SAMPLE_CYC);
    localparam logic [IDX_W-1:0] END64   = IDX_W'(CODE_W - 1);
    localparam logic [IDX_W-1:0] END32   = IDX_W'(HALF_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  cidx;
    logic [CODE_W-1:0] sreg;
    logic              long_q;
    logic              os12_q;
    logic              chip_end;

    assign chip_end = busy && (cnt == CNT_END);
    assign last     = chip_end && (cidx == (long_q ? END64 : END32));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cidx   <= '0;
            sreg   <= '0;
            long_q <= 1'b0;
            os12_q <= 1'b0;
        end else if (load) begin
            busy   <= 1'b1;
            cnt    <= '0;
            cidx   <= '0;
            sreg   <= sym.chips;
            long_q <= sym.long64;
            os12_q <= sym.os12;
        end else if (busy) begin
            if (chip_end) begin
                cnt  <= '0;
                sreg <= {sreg[CODE_W-2:0], 1'b0};
                cidx <= cidx + 1'b1;
                if (last) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign chip_en  = busy && (cnt == '0);
    assign chip_out = busy && sreg[CODE_W-1];
    assign os_phase = !busy ? '0 :
                      os12_q ? OSP_W'(cnt / DIV12) : OSP_W'(cnt / DIV6);

    assert_load_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        load |-> (!busy || last));
    assert_chip_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        chip_en |=> !chip_en);
    assert_chip_hold_R6: assert property (@(posedge clk) disable iff (rst)
        busy && !chip_end |=> chip_out == $past(chip_out));
    assert_phase_range_R7: assert property (@(posedge clk) disable iff (rst)
        busy && !os12_q |-> os_phase < 4'd6);
    assert_idle_phase_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> os_phase == '0 && !chip_en);

endmodule

// File: rtl/pn_spreader.sv
module pn_spreader
    import pn_spread_pkg::*;
#(
    parameter int SAMPLE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [REG_W-1:0]  mode_wdata,
    output logic [REG_W-1:0]  mode_rdata,
    output logic              mode_err,
    input  logic [CODE_W-1:0] code_word,
    input  logic              bit_valid,
    input  logic              bit_data,
    output logic              bit_ready,
    output logic              chip_en,
    output logic              chip_out,
    output logic [OSP_W-1:0]  os_phase
);

    mode_t mode;
    logic  seq_busy;
    logic  seq_last;
    logic  load;
    sym_t  sym;

    pn_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (mode),
        .rdata (mode_rdata),
        .err   (mode_err)
    );

    pn_sym_builder u_build (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .code      (code_word),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .seq_busy  (seq_busy),
        .seq_last  (seq_last),
        .bit_ready (bit_ready),
        .load      (load),
        .sym       (sym)
    );

    pn_chip_seq #(.SAMPLE_CYC(SAMPLE_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .sym      (sym),
        .busy     (seq_busy),
        .last     (seq_last),
        .chip_en  (chip_en),
        .chip_out (chip_out),
        .os_phase (os_phase)
    );

    assert_ready_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> bit_ready);

endmodule

// File: tb/pn_spreader_tb_top.sv
`timescale 1ns/1ps
module pn_spreader_tb_top;

    localparam int CPC = 12;
    localparam logic [63:0] CODE = 64'hF0E1_D2C3_B4A5_9687;

    // {mode[2:0], first bit, second bit}
    localparam logic [4:0] VEC [10] = '{
        5'b000_1_0, 5'b000_0_0, 5'b100_1_0, 5'b100_0_0, 5'b101_1_0,
        5'b101_0_0, 5'b110_0_0, 5'b110_0_1, 5'b110_1_0, 5'b110_1_1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata;
    logic       mode_err;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       bit_ready;
    logic       chip_en;
    logic       chip_out;
    logic [3:0] os_phase;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pn_spreader dut_i (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .mode_rdata(mode_rdata), .mode_err(mode_err), .code_word(CODE),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
        .chip_en(chip_en), .chip_out(chip_out), .os_phase(os_phase)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        applied++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_sym(input logic [2:0] m, input logic d0,
                                            input logic d1, output int n);
        logic [31:0] h;
        h = d0 ? CODE[63:32] : CODE[31:0];
        if (m == 3'b000) begin n = 64; return d0 ? CODE : ~CODE; end
        n = 32;
        if (m == 3'b110) return {(d1 ? h : ~h), 32'b0};
        return {h, 32'b0};
    endfunction

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(posedge clk); #1 mode_we = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_valid = 1'b1; bit_data = b;
        while (!bit_ready) @(negedge clk);
        @(posedge clk); #1 bit_valid = 1'b0;
    endtask

    // collects n chips from the next negedge on, then watches 2 idle chip periods
    task automatic collect(input int n, output logic [63:0] got, output int maxph,
                           output int first_at, output bit timing_bad, output int extra);
        int k = 0, cyc = 0, last_en = 0;
        logic cur = 1'b0;
        got = '0; maxph = 0; first_at = -1; timing_bad = 1'b0; extra = 0;
        while (k < n || cyc - last_en < CPC) begin
            @(negedge clk); cyc++;
            if (int'(os_phase) > maxph) maxph = int'(os_phase);
            if (chip_en) begin
                if (k >= n) extra++;
                else begin
                    if (k == 0) first_at = cyc;
                    else if (cyc - last_en != CPC) timing_bad = 1'b1;
                    if (os_phase != 0) timing_bad = 1'b1;
                    got[63-k] = chip_out; cur = chip_out; k++; last_en = cyc;
                end
            end else if (k > 0 && cyc - last_en < CPC && chip_out != cur) timing_bad = 1'b1;
        end
        repeat (2*CPC) begin @(negedge clk); if (chip_en) extra++; end
    endtask

    initial begin
        #800000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] got, exp;
        int n, mx, fa, ex, low;
        bit tb;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(mode_rdata == 8'h00, "R10 mode after reset", 64'(mode_rdata), 64'h0);
        chk(mode_err == 1'b0, "R10 err after reset", 64'(mode_err), 64'h0);
        chk(chip_en == 1'b0 && os_phase == 0, "R10 idle chips", 64'(chip_en), 64'h0);
        chk(bit_ready == 1'b1, "R10 ready after reset", 64'(bit_ready), 64'h1);

        // table: R3 R4 R5 R6 R7
        foreach (VEC[i]) begin
            write_mode({5'b0, VEC[i][4:2]});
            exp = exp_sym(VEC[i][4:2], VEC[i][1], VEC[i][0], n);
            if (VEC[i][4:2] == 3'b110) begin send_bit(VEC[i][1]); send_bit(VEC[i][0]); end
            else send_bit(VEC[i][1]);
            collect(n, got, mx, fa, tb, ex);
            chk(got == exp, "R3/R4/R5 chip pattern", got, exp);
            chk(ex == 0, "R3/R4/R5 symbol length", 64'(ex), 64'h0);
            chk(!tb && fa == 1, "R6 chip timing", 64'(tb), 64'h0);
            chk(mx == ((VEC[i][4:2] == 3'b101) ? 11 : 5), "R7 phase range",
                64'(mx), (VEC[i][4:2] == 3'b101) ? 64'd11 : 64'd5);
        end

        // R1 reserved bits ignored and read as zero
        write_mode(8'hFD);
        @(negedge clk);
        chk(mode_rdata == 8'h05, "R1 reserved read zero", 64'(mode_rdata), 64'h05);
        chk(mode_err == 1'b0, "R1 legal write no err", 64'(mode_err), 64'h0);

        // R2 illegal writes flagged, value held
        foreach (VEC[i]) if (i < 4) begin
            logic [7:0] bad;
            bad = (i == 0) ? 8'h01 : (i == 1) ? 8'h02 : (i == 2) ? 8'h03 : 8'h07;
            write_mode(bad);
            @(negedge clk);
            chk(mode_err == 1'b1, "R2 illegal flagged", 64'(mode_err), 64'h1);
            chk(mode_rdata == 8'h05, "R2 illegal held", 64'(mode_rdata), 64'h05);
        end
        send_bit(1'b1);
        collect(32, got, mx, fa, tb, ex);
        chk(got == {CODE[63:32], 32'b0} && ex == 0, "R2 held mode used", got, {CODE[63:32], 32'b0});
        chk(mx == 11, "R2 held mode 12x phase", 64'(mx), 64'd11);
        write_mode(8'h04);
        @(negedge clk);
        chk(mode_err == 1'b0 && mode_rdata == 8'h04, "R2 legal clears err",
            64'({mode_err, mode_rdata}), 64'h004);

        // R8 ready timing and seamless back-to-back
        send_bit(1'b1);
        low = 0;
        forever begin
            @(negedge clk);
            if (bit_ready) break;
            low++;
        end
        chk(low == 32*CPC-1, "R8 ready in last cycle", 64'(low), 64'(32*CPC-1));
        bit_valid = 1'b1; bit_data = 1'b0;
        @(posedge clk); #1 bit_valid = 1'b0;
        collect(32, got, mx, fa, tb, ex);
        chk(fa == 1 && !tb, "R8 no gap back-to-back", 64'(fa), 64'h1);
        chk(got == {CODE[31:0], 32'b0}, "R8 second symbol", got, {CODE[31:0], 32'b0});

        // R8 double rate: first bit of next pair taken mid-symbol
        write_mode(8'h06);
        send_bit(1'b0); send_bit(1'b0);
        @(negedge clk);
        chk(bit_ready == 1'b1, "R8 ddr first bit ready", 64'(bit_ready), 64'h1);
        send_bit(1'b1);
        @(negedge clk);
        chk(bit_ready == 1'b0, "R8 ddr pair held not ready", 64'(bit_ready), 64'h0);
        send_bit(1'b1);
        collect(32, got, mx, fa, tb, ex);
        chk(got == {CODE[63:32], 32'b0} && fa == 1, "R5 ddr next pair", got, {CODE[63:32], 32'b0});

        // R9 mode change mid-symbol
        write_mode(8'h00);
        send_bit(1'b1);
        fork
            collect(64, got, mx, fa, tb, ex);
            begin repeat (100) @(negedge clk); mode_we = 1'b1; mode_wdata = 8'h04;
                  @(posedge clk); #1 mode_we = 1'b0; end
        join
        chk(got == CODE && ex == 0, "R9 symbol unaffected", got, CODE);
        send_bit(1'b0);
        collect(32, got, mx, fa, tb, ex);
        chk(got == {CODE[31:0], 32'b0} && ex == 0, "R9 new mode next symbol", got, {CODE[31:0], 32'b0});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule